// File: doc/BRIEF.md
# Serial Port Register Block

This block is the register face of a serial port, seen from a 32-bit, word-addressed bus. A 16-byte receive FIFO takes bytes from a valid/ready byte stream. Each bus write to the transmit data word sends one byte out on a byte stream as a single-cycle strobe. A small interrupt unit sets raw event bits, ANDs them with a mask and drives one level interrupt line.

Software reads receive data from one of two status/data words. One reading leaves the FIFO untouched. The other also takes the oldest byte out. Software clears transmit events by writing ones to an acknowledge word. Directly after a transmit write, that acknowledge holds back one extra write before the transmit-done bit can be cleared. The receive-data bit follows the FIFO fill state at all times. Control words with no function of their own are plain read/write storage.

Bus reads are combinational in the same cycle. A pop read and every write take effect at the rising clock edge. Bit-level serialization, baud timing and DMA are not part of this block.

Top module: `sio_regblock`

## Requirements
- R1: After reset, the receive control word (byte offset 0x08) reads 0x0001_0000 and the mask (0x2C), acknowledge (0x30) and raw (0x34) words read 0. The FIFO is empty, tx_valid is 0, rx_ready is 0 and irq is 0.
- R2: A read at 0x20 or 0x24 returns a status word. Bits 7:0 hold the oldest FIFO byte and bit 16 is 1 exactly when the FIFO holds data. Bits 22 and 24 are always 1 and all other bits are 0.
- R3: When the FIFO is non-empty, a read at 0x20 removes the oldest byte at the clock edge. A read at 0x24 never changes the FIFO.
- R4: The FIFO keeps up to 16 bytes in arrival order and wraps around its storage. While it holds 16 bytes, rx_ready is low and no byte is stored.
- R5: rx_ready is 1 only while bit 3 of the receive control word is 1. A byte is taken when rx_valid and rx_ready are both 1. When a pop read at 0x20 and an incoming byte meet on a full FIFO in one cycle, the pop is applied first, rx_ready is 1 and the byte is stored.
- R6: Raw interrupt bit 3 is 1 exactly when the FIFO holds data. A write to the acknowledge word does not clear it.
- R7: A write to 0x1C stores the full 32-bit value, which reads back at 0x1C. In the next cycle tx_valid is 1 for exactly one cycle, and tx_data carries bits 7:0 of the written value. The write also sets raw bits 0 and 1 and sets a pending-transmit flag.
- R8: A write to 0x30 clears each raw bit that is 1 in the written value, and the written value reads back at 0x30. If the pending-transmit flag is set, bit 0 is first dropped from the value (both for clearing and for the stored copy), and the flag is cleared.
- R9: The word at 0x38 equals raw AND mask. irq is 1 exactly when that word is non-zero, and it follows a register write in the next cycle.
- R10: Words inside the 0x00–0x38 window that have no function of their own (for example 0x00, 0x04, 0x10, 0x28) read back the last value written. Reads at 0x3C return 0. Writes at 0x20, 0x24, 0x38 and 0x3C change nothing.
- R11: A write to the raw word at 0x34 replaces all raw bits except bit 3, which keeps following the FIFO state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Block takes the byte this cycle |
| tx_valid | output | 1 | One-cycle strobe per transmit write |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt, any masked raw bit set |

## Verification
The assertions assume that there is at most one bus access per cycle and that the address and data are known whenever bus_sel is high. They also assume that rx_valid and rx_data are never X. The FIFO-count properties assume the receive stream is only sampled through rx_ready, so that a byte offered while rx_ready is low has no effect. The bench drives exactly one bus operation or idle per cycle from a single task and changes inputs only on falling edges. It offers receive bytes both while the receiver is disabled and while the FIFO is full, so the count checks are exercised in those cases.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned ADDR_W     = 6;
    localparam int unsigned FIFO_DEPTH = 16;
    localparam int unsigned IDX_W      = ADDR_W - 2;
    localparam int unsigned NUM_WORDS  = 15;

    // word indices (byte offset / 4)
    localparam logic [IDX_W-1:0] W_RX_CTRL    = 4'd2;
    localparam logic [IDX_W-1:0] W_TX_DATA    = 4'd7;
    localparam logic [IDX_W-1:0] W_STAT_POP   = 4'd8;
    localparam logic [IDX_W-1:0] W_STAT_PEEK  = 4'd9;
    localparam logic [IDX_W-1:0] W_IRQ_MASK   = 4'd11;
    localparam logic [IDX_W-1:0] W_IRQ_ACK    = 4'd12;
    localparam logic [IDX_W-1:0] W_IRQ_RAW    = 4'd13;
    localparam logic [IDX_W-1:0] W_IRQ_MASKED = 4'd14;

    localparam int unsigned RX_EN_BIT   = 3;
    localparam int unsigned ST_AVAIL    = 16;
    localparam int unsigned ST_TX_IDLE  = 22;
    localparam int unsigned ST_TX_RDY   = 24;
    localparam int unsigned IRQ_RX_BIT  = 3;

    localparam logic [DATA_W-1:0] RX_CTRL_RST = 32'h0001_0000;

    typedef struct packed {
        logic                 wr_en;
        logic                 rd_en;
        logic                 in_win;
        logic [IDX_W-1:0]     idx;
    } bus_dec_t;

    function automatic logic [DATA_W-1:0] status_word(input logic [BYTE_W-1:0] head,
                                                      input logic avail);
        logic [DATA_W-1:0] w;
        w             = '0;
        w[BYTE_W-1:0] = head;
        w[ST_AVAIL]   = avail;
        w[ST_TX_IDLE] = 1'b1;
        w[ST_TX_RDY]  = 1'b1;
        return w;
    endfunction

    function automatic logic is_plain(input int i);
        return !(i == int'(W_STAT_POP)  || i == int'(W_STAT_PEEK) ||
                 i == int'(W_IRQ_MASK)  || i == int'(W_IRQ_ACK)   ||
                 i == int'(W_IRQ_RAW)   || i == int'(W_IRQ_MASKED));
    endfunction

    function automatic logic [DATA_W-1:0] store_reset(input int i);
        return (i == int'(W_RX_CTRL)) ? RX_CTRL_RST : '0;
    endfunction

endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             pop_eff, push_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign pop_eff = pop & ~empty;
    // a pop in the same cycle frees the slot for the incoming byte
    assign push_ok = push & (~full | pop_eff);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_eff) rd_ptr <= ptr_inc(rd_ptr);
            case ({push_ok, pop_eff})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl #(
    parameter int unsigned W        = 32,
    parameter int unsigned LIVE_BIT = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_wr,
    input  logic         ack_wr,
    input  logic         raw_wr,
    input  logic         mask_wr,
    input  logic [W-1:0] wdata,
    input  logic         rx_avail,
    output logic [W-1:0] raw,
    output logic [W-1:0] mask,
    output logic [W-1:0] masked,
    output logic [W-1:0] ack_val,
    output logic         irq
);

    localparam logic [W-1:0] TX_EVENTS = W'(3);
    localparam logic [W-1:0] TX_DONE   = W'(1);
    localparam logic [W-1:0] LIVE_MASK = W'(1) << LIVE_BIT;

    logic [W-1:0] raw_q, mask_q, ack_q, ack_eff;
    logic         pend_q;

    // first acknowledge after a transmit keeps the done bit
    assign ack_eff = pend_q ? (wdata & ~TX_DONE) : wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
            ack_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (tx_wr) begin
                raw_q  <= raw_q | TX_EVENTS;
                pend_q <= 1'b1;
            end else if (ack_wr) begin
                ack_q  <= ack_eff;
                raw_q  <= raw_q & ~ack_eff;
                pend_q <= 1'b0;
            end else if (raw_wr) begin
                raw_q  <= wdata;
            end
            if (mask_wr) mask_q <= wdata;
        end
    end

    assign raw     = (raw_q & ~LIVE_MASK) | (W'(rx_avail) << LIVE_BIT);
    assign mask    = mask_q;
    assign ack_val = ack_q;
    assign masked  = raw & mask_q;
    assign irq     = |masked;

endmodule

// File: rtl/sio_regblock.sv
module sio_regblock
    import sio_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH_P = sio_pkg::FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);

    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH_P + 1);

    bus_dec_t          dec;
    logic              unused_lsb;
    logic [DATA_W-1:0] word_val [NUM_WORDS];
    logic              rx_en, pop_req, pop_now, push_now;
    logic [BYTE_W-1:0] fifo_head;
    logic [CNT_W-1:0]  fifo_count;
    logic              fifo_full, fifo_empty;
    logic [DATA_W-1:0] irq_raw, irq_mask, irq_masked, irq_ack;

    // ---------------- decode ----------------
    assign unused_lsb = ^bus_addr[1:0];
    assign dec.idx    = bus_addr[ADDR_W-1:2];
    assign dec.in_win = (dec.idx < IDX_W'(NUM_WORDS));
    assign dec.wr_en  = bus_sel & bus_wr & dec.in_win;
    assign dec.rd_en  = bus_sel & ~bus_wr;

    assign pop_req = dec.rd_en & (dec.idx == W_STAT_POP);

    // ---------------- plain storage words ----------------
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        if (is_plain(g)) begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= store_reset(g);
                else if (dec.wr_en && dec.idx == IDX_W'(g))
                    q <= bus_wdata;
            end
            assign word_val[g] = q;
        end else begin : g_special
            assign word_val[g] = '0;
        end
    end

    assign rx_en = word_val[W_RX_CTRL][RX_EN_BIT];

    // ---------------- receive path ----------------
    assign pop_now  = pop_req & ~fifo_empty;
    assign rx_ready = rx_en & (~fifo_full | pop_now);
    assign push_now = rx_valid & rx_ready;

    sio_rx_fifo #(
        .DEPTH (FIFO_DEPTH_P),
        .W     (BYTE_W)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push_now),
        .push_data (rx_data),
        .pop       (pop_req),
        .head      (fifo_head),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    // ---------------- transmit path ----------------
    logic tx_wr;
    assign tx_wr = dec.wr_en & (dec.idx == W_TX_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= tx_wr;
            if (tx_wr) tx_data <= bus_wdata[BYTE_W-1:0];
        end
    end

    // ---------------- interrupts ----------------
    sio_irq_ctrl #(
        .W        (DATA_W),
        .LIVE_BIT (IRQ_RX_BIT)
    ) u_irq (
        .clk      (clk),
        .rst      (rst),
        .tx_wr    (tx_wr),
        .ack_wr   (dec.wr_en & (dec.idx == W_IRQ_ACK)),
        .raw_wr   (dec.wr_en & (dec.idx == W_IRQ_RAW)),
        .mask_wr  (dec.wr_en & (dec.idx == W_IRQ_MASK)),
        .wdata    (bus_wdata),
        .rx_avail (~fifo_empty),
        .raw      (irq_raw),
        .mask     (irq_mask),
        .masked   (irq_masked),
        .ack_val  (irq_ack),
        .irq      (irq)
    );

    // ---------------- read mux ----------------
    always_comb begin
        case (dec.idx)
            W_STAT_POP, W_STAT_PEEK: bus_rdata = status_word(fifo_head, ~fifo_empty);
            W_IRQ_MASK:              bus_rdata = irq_mask;
            W_IRQ_ACK:               bus_rdata = irq_ack;
            W_IRQ_RAW:               bus_rdata = irq_raw;
            W_IRQ_MASKED:            bus_rdata = irq_masked;
            default:                 bus_rdata = dec.in_win ? word_val[dec.idx] : '0;
        endcase
    end

endmodule

// File: rtl/sio_regblock_chk.sv
module sio_regblock_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [5:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             rx_ready,
    input logic             tx_valid,
    input logic             irq,
    input logic             rx_en,
    input logic             pop_now,
    input logic             push_now,
    input logic [CNT_W-1:0] fifo_count
);

    logic       is_read, is_stat;
    logic [3:0] widx;
    assign widx    = bus_addr[5:2];
    assign is_read = bus_sel && !bus_wr;
    assign is_stat = is_read && (widx == 4'd8 || widx == 4'd9);

    AST_STAT_CONST_BITS: assert property (@(posedge clk) disable iff (rst)
        is_stat |-> (bus_rdata[24] && bus_rdata[22])); // R2

    AST_STAT_AVAIL: assert property (@(posedge clk) disable iff (rst)
        is_stat |-> (bus_rdata[16] == (fifo_count != '0))); // R2

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (pop_now && !push_now) |=> (fifo_count == $past(fifo_count) - CNT_W'(1))); // R3

    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (is_read && widx == 4'd9 && !push_now) |=> $stable(fifo_count)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(DEPTH)); // R4

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == CNT_W'(DEPTH) && !pop_now) |-> !rx_ready); // R4

    AST_RX_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !rx_en |-> !rx_ready); // R5

    AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(bus_sel && bus_wr && bus_addr[5:2] == 4'd7)); // R7

    AST_IRQ_VS_MASKED: assert property (@(posedge clk) disable iff (rst)
        (is_read && widx == 4'd14) |-> (irq == (bus_rdata != '0))); // R9

endmodule

bind sio_regblock sio_regblock_chk #(.DEPTH(FIFO_DEPTH_P)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .irq        (irq),
    .rx_en      (rx_en),
    .pop_now    (pop_now),
    .push_now   (push_now),
    .fifo_count (fifo_count)
);

// File: tb/sio_regblock_bench.sv
`timescale 1ns/1ps
module sio_regblock_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    always #4 clk = ~clk;  // 125 MHz

    sio_regblock u_sio_regblock (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    // kinds: 0 read data, 1 irq, 2 rx_ready, 3 {tx_valid, tx_data}
    typedef struct {
        int          kind;
        logic [31:0] exp;
        logic [31:0] msk;
        string       tag;
    } item_t;

    item_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // monitor: compares everything queued for this cycle, mid-phase
    always @(negedge clk) begin
        #3;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'b0, irq};
                2:       act = {31'b0, rx_ready};
                default: act = {23'b0, tx_valid, tx_data};
            endcase
            n_cmp++;
            if ((act & it.msk) !== (it.exp & it.msk)) begin
                n_bad++;
                $display("FAIL %s: kind %0d actual %h expected %h", it.tag, it.kind,
                         act & it.msk, it.exp & it.msk);
            end
        end
    end

    task automatic expect_item(input int kind, input logic [31:0] exp,
                               input logic [31:0] msk, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.msk = msk; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic step(input logic sel, input logic wr, input logic [5:0] a,
                        input logic [31:0] d, input logic rv, input logic [7:0] rb);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        rx_valid = rv; rx_data = rb;
    endtask

    task automatic idle();
        step(0, 0, 6'h0, 32'h0, 0, 8'h0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0, 8'h0);
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e,
                      input logic [31:0] m, input string tag);
        step(1, 0, a, 32'h0, 0, 8'h0);
        expect_item(0, e, m, tag);
    endtask

    task automatic push_byte(input logic [7:0] b);
        step(0, 0, 6'h0, 32'h0, 1, b);
        expect_item(2, 1, 1, "R4 accept");
    endtask

    task automatic do_reset();
        @(negedge clk);
        bus_sel = 0; rx_valid = 0; rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    localparam logic [31:0] ST = 32'h0141_0000;  // status with data
    localparam logic [31:0] SE = 32'h0140_0000;  // status, empty
    localparam logic [31:0] ALL = 32'hFFFF_FFFF;
    localparam logic [31:0] HI  = 32'hFFFF_FF00;

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        idle();
        expect_item(1, 0, 1, "R1 irq");
        expect_item(2, 0, 1, "R1 rx_ready");
        expect_item(3, 0, 32'h100, "R1 tx_valid");
        rd(6'h08, 32'h0001_0000, ALL, "R1 rx ctrl");
        rd(6'h2C, 0, ALL, "R1 mask");
        rd(6'h30, 0, ALL, "R1 ack");
        rd(6'h34, 0, ALL, "R1 raw");
        rd(6'h24, SE, HI, "R1 empty / R2");

        // R5 disabled receiver
        step(0, 0, 0, 0, 1, 8'h55);
        expect_item(2, 0, 1, "R5 disabled ready");
        rd(6'h24, SE, HI, "R5 nothing taken");

        wr(6'h08, 32'h8);
        rd(6'h08, 32'h8, ALL, "R10 rx ctrl storage");
        push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
        rd(6'h24, ST | 32'h11, ALL, "R2 peek");
        rd(6'h24, ST | 32'h11, ALL, "R3 peek keeps");
        rd(6'h34, 32'h8, ALL, "R6 raw bit3");
        rd(6'h38, 0, ALL, "R9 masked zero");
        expect_item(1, 0, 1, "R9 irq low");

        wr(6'h2C, 32'h8);
        rd(6'h38, 32'h8, ALL, "R9 masked");
        expect_item(1, 1, 1, "R9 irq high");
        rd(6'h20, ST | 32'h11, ALL, "R3 pop 1");
        rd(6'h20, ST | 32'h22, ALL, "R3 pop 2");
        rd(6'h20, ST | 32'h33, ALL, "R3 pop 3");
        rd(6'h24, SE, HI, "R3 emptied");
        rd(6'h34, 0, ALL, "R6 raw follows empty");
        expect_item(1, 0, 1, "R9 irq drops");

        // R4 fill, overflow, wrap; R5 pop-then-accept
        for (int i = 0; i < 16; i++) push_byte(8'h40 + 8'(i));
        step(0, 0, 0, 0, 1, 8'h99);
        expect_item(2, 0, 1, "R4 full ready low");
        rd(6'h24, ST | 32'h40, ALL, "R4 oldest kept");
        step(1, 0, 6'h20, 0, 1, 8'hA5);
        expect_item(0, ST | 32'h40, ALL, "R5 pop data");
        expect_item(2, 1, 1, "R5 pop frees slot");
        for (int i = 1; i < 16; i++) rd(6'h20, ST | (32'h40 + i), ALL, "R4 order");
        rd(6'h20, ST | 32'hA5, ALL, "R5 byte after pop");
        rd(6'h24, SE, HI, "R4 drained");

        // R7 transmit
        wr(6'h1C, 32'h1234_56C3);
        rd(6'h1C, 32'h1234_56C3, ALL, "R7 stored");
        expect_item(3, 32'h1C3, 32'h1FF, "R7 tx byte");
        rd(6'h34, 32'h3, ALL, "R7 raw bits");
        expect_item(3, 0, 32'h100, "R7 single strobe");

        // R8 acknowledge with pending flag
        wr(6'h30, 32'h3);
        rd(6'h34, 32'h1, ALL, "R8 bit0 held");
        rd(6'h30, 32'h2, ALL, "R8 stored ack");
        wr(6'h30, 32'h1);
        rd(6'h34, 0, ALL, "R8 second ack clears");

        wr(6'h2C, 32'h1);
        wr(6'h1C, 32'h5A);
        idle();
        expect_item(1, 1, 1, "R9 irq tx");
        expect_item(3, 32'h15A, 32'h1FF, "R7 tx byte 2");
        wr(6'h30, 32'h1);
        idle();
        expect_item(1, 1, 1, "R8 first ack kept");
        wr(6'h30, 32'h1);
        idle();
        expect_item(1, 0, 1, "R8 cleared");

        // R11 raw write
        wr(6'h2C, 32'h18);
        wr(6'h34, 32'h10);
        rd(6'h34, 32'h10, ALL, "R11 raw stored");
        expect_item(1, 1, 1, "R11 irq");
        wr(6'h34, 32'h8);
        rd(6'h34, 32'h0, ALL, "R11 bit3 live");
        wr(6'h30, 32'h10);
        rd(6'h34, 0, ALL, "R11 cleared");

        // R6 ack cannot clear receive bit
        push_byte(8'h77);
        idle();
        expect_item(1, 1, 1, "R6 irq on data");
        wr(6'h30, 32'h8);
        rd(6'h34, 32'h8, ALL, "R6 ack ignored");
        expect_item(1, 1, 1, "R6 irq stays");
        rd(6'h20, ST | 32'h77, ALL, "R6 pop");
        rd(6'h34, 0, ALL, "R6 cleared by empty");
        expect_item(1, 0, 1, "R6 irq low");

        // R10 storage and ignored writes
        wr(6'h38, ALL);
        rd(6'h38, 0, ALL, "R10 masked write ignored");
        wr(6'h24, ALL);
        rd(6'h24, SE, HI, "R10 status write ignored");
        wr(6'h10, 32'hDEAD_BEEF);
        rd(6'h10, 32'hDEAD_BEEF, ALL, "R10 storage");
        wr(6'h28, 32'h0BAD_F00D);
        rd(6'h28, 32'h0BAD_F00D, ALL, "R10 storage 2");
        wr(6'h3C, ALL);
        rd(6'h3C, 0, ALL, "R10 out of window");

        // R5 disable again
        wr(6'h08, 32'h0);
        step(0, 0, 0, 0, 1, 8'h66);
        expect_item(2, 0, 1, "R5 disabled again");
        rd(6'h24, SE, HI, "R5 no accept");

        // R1 reset mid-run
        wr(6'h08, 32'h8);
        push_byte(8'h12);
        do_reset();
        rd(6'h24, SE, HI, "R1 fifo cleared");
        rd(6'h08, 32'h0001_0000, ALL, "R1 rx ctrl again");
        rd(6'h2C, 0, ALL, "R1 mask again");
        expect_item(1, 0, 1, "R1 irq again");

        idle(); idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule